// File: doc/BRIEF.md
# Pipeline Hazard and Redirect Controller

This block makes the hazard and control-flow decisions for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Each cycle it takes the register fields, valid bits, load flags and register-write flags of the instructions that sit in the decode, execute, memory and write-back stages. It also takes the taken flag and target address of a branch or jump being resolved in execute. From these it drives the PC and decode-register write enables, a bubble request for the decode/execute register, flushes for the two front pipeline registers, the next-PC choice and the operand bypass selects for the execute stage.

Branches and jumps resolve in execute. A taken transfer therefore discards the two younger instructions in fetch and decode, and fetch resumes at the target. A load whose result is read by the instruction right behind it holds fetch and decode for one cycle and inserts one bubble. After that the loaded value reaches execute through the bypass path. A redirect overrides a load-use hold raised in the same cycle. All decisions are combinational on the stage inputs. The only exception is a one-cycle qualifier after reset that keeps every hold and flush quiet.

Top module: `hz_ctrl_top`

## Requirements
- R1: In the first cycle after reset is released, no hold, bubble or flush is asserted, pc_sel is 0 and pc_next equals cur_pc plus 4, whatever the stage inputs.
- R2: With no hazard, pc_we and ifid_we are 1, idex_bubble, ifid_flush, idex_flush and pc_sel are 0, and pc_next equals cur_pc plus 4.
- R3: A valid load in execute with a non-zero destination that equals a used source (rs1 with id_use_rs1, or rs2 with id_use_rs2) of a valid decode instruction drives pc_we=0, ifid_we=0 and idex_bubble=1. A non-load in execute never does this.
- R4: A source field that its use flag marks as unused never causes a hold, even when it matches the load destination.
- R5: A destination of register 0 never causes a hold and is never selected for bypass.
- R6: A valid taken transfer in execute drives ifid_flush=1, idex_flush=1, pc_sel=1 and pc_next=ex_target.
- R7: When a taken transfer and a load-use condition occur together, the flushes are asserted and the hold is dropped (pc_we=1, ifid_we=1, idex_bubble=0).
- R8: Each bypass select is 2'b10 when the memory-stage instruction writes the execute source, else 2'b01 when the write-back-stage instruction writes it, else 2'b00 (register file). The memory stage wins when both match.
- R9: A stage feeds the bypass only when its valid and register-write flags are both 1.
- R10: An invalid decode or execute instruction raises neither a hold nor a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode instruction is valid |
| id_rs1 | input | 5 | Decode first source register |
| id_rs2 | input | 5 | Decode second source register |
| id_use_rs1 | input | 1 | Decode instruction reads rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads rs2 |
| ex_valid | input | 1 | Execute instruction is valid |
| ex_rs1 | input | 5 | Execute first source register |
| ex_rs2 | input | 5 | Execute second source register |
| ex_rd | input | 5 | Execute destination register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_taken | input | 1 | Execute branch/jump is taken |
| ex_target | input | 32 | Execute transfer target |
| mem_valid | input | 1 | Memory-stage instruction is valid |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_reg_we | input | 1 | Memory-stage instruction writes a register |
| wb_valid | input | 1 | Write-back instruction is valid |
| wb_rd | input | 5 | Write-back destination register |
| wb_reg_we | input | 1 | Write-back instruction writes a register |
| cur_pc | input | 32 | Current program counter |
| pc_we | output | 1 | PC update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| idex_bubble | output | 1 | Load a bubble into decode/execute |
| ifid_flush | output | 1 | Clear fetch/decode register |
| idex_flush | output | 1 | Clear decode/execute register |
| pc_sel | output | 1 | 1 selects the transfer target |
| pc_next | output | 32 | Next PC value |
| fwd_a | output | 2 | Bypass select for first operand |
| fwd_b | output | 2 | Bypass select for second operand |

## Verification
The bench builds the block with its default parameters: 5-bit register indices and a 32-bit PC, so the PC step is 4. With these values register 0, the full index range and the byte-addressed target are all within reach. A vector table drives each hazard class in isolation and in combination, including the flush-versus-hold overlap and both bypass stages matching the same source. Directed steps then check the quiet first cycle after reset and walk a load and its consumer through the one-cycle hold into the write-back bypass.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
  parameter int RA_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RA_W-1:0]     src,
  input  logic                mem_valid,
  input  logic                mem_we,
  input  logic [RA_W-1:0]     mem_rd,
  input  logic                wb_valid,
  input  logic                wb_we,
  input  logic [RA_W-1:0]     wb_rd,
  output hz_pkg::fwd_sel_e    sel
);
  logic mem_hit, wb_hit, src_nz;

  always_comb begin
    src_nz  = (src != '0);
    mem_hit = mem_valid && mem_we && src_nz && (mem_rd == src);
    wb_hit  = wb_valid  && wb_we  && src_nz && (wb_rd  == src);
    if (mem_hit)     sel = hz_pkg::FWD_MEM;
    else if (wb_hit) sel = hz_pkg::FWD_WB;
    else             sel = hz_pkg::FWD_RF;
  end

  // R5
  x0_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == hz_pkg::FWD_RF));

  // R9
  fwd_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == hz_pkg::FWD_MEM) |-> (mem_valid && mem_we));
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
  parameter int RA_W = 5
) (
  input  logic            live,
  input  logic            id_valid,
  input  logic [RA_W-1:0] id_rs1,
  input  logic [RA_W-1:0] id_rs2,
  input  logic            id_use_rs1,
  input  logic            id_use_rs2,
  input  logic            ex_valid,
  input  logic            ex_is_load,
  input  logic [RA_W-1:0] ex_rd,
  output logic            hit
);
  logic rd_nz, m1, m2;

  always_comb begin
    rd_nz = (ex_rd != '0);
    m1    = id_use_rs1 && (id_rs1 == ex_rd);
    m2    = id_use_rs2 && (id_rs2 == ex_rd);
    hit   = live && id_valid && ex_valid && ex_is_load && rd_nz && (m1 || m2);
  end
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect #(
  parameter int PC_W = 32,
  parameter int STEP = 4
) (
  input  logic            live,
  input  logic            ex_valid,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] ex_target,
  input  logic [PC_W-1:0] cur_pc,
  output logic            take,
  output logic [PC_W-1:0] pc_next
);
  always_comb begin
    take    = live && ex_valid && ex_taken;
    pc_next = take ? ex_target : (cur_pc + PC_W'(STEP));
  end
endmodule

// File: rtl/hz_ctrl_top.sv
module hz_ctrl_top #(
  parameter int RA_W = 5,
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid,
  input  logic [RA_W-1:0] id_rs1,
  input  logic [RA_W-1:0] id_rs2,
  input  logic            id_use_rs1,
  input  logic            id_use_rs2,
  input  logic            ex_valid,
  input  logic [RA_W-1:0] ex_rs1,
  input  logic [RA_W-1:0] ex_rs2,
  input  logic [RA_W-1:0] ex_rd,
  input  logic            ex_is_load,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] ex_target,
  input  logic            mem_valid,
  input  logic [RA_W-1:0] mem_rd,
  input  logic            mem_reg_we,
  input  logic            wb_valid,
  input  logic [RA_W-1:0] wb_rd,
  input  logic            wb_reg_we,
  input  logic [PC_W-1:0] cur_pc,
  output logic            pc_we,
  output logic            ifid_we,
  output logic            idex_bubble,
  output logic            ifid_flush,
  output logic            idex_flush,
  output logic            pc_sel,
  output logic [PC_W-1:0] pc_next,
  output logic [1:0]      fwd_a,
  output logic [1:0]      fwd_b
);
  localparam int STEP   = PC_W / 8;
  localparam int N_OPND = 2;

  logic live_q, live_d, live_en;
  logic lu_hit, take, hold;
  logic [RA_W-1:0]  ex_src [N_OPND];
  hz_pkg::fwd_sel_e sel_w  [N_OPND];

  always_comb begin
    live_en = !live_q;
    live_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= 1'b0;
    else if (live_en) live_q <= live_d;
  end

  hz_loaduse #(.RA_W(RA_W)) u_lu (
    .live(live_q), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .ex_valid(ex_valid),
    .ex_is_load(ex_is_load), .ex_rd(ex_rd), .hit(lu_hit)
  );

  hz_redirect #(.PC_W(PC_W), .STEP(STEP)) u_rd (
    .live(live_q), .ex_valid(ex_valid), .ex_taken(ex_taken),
    .ex_target(ex_target), .cur_pc(cur_pc), .take(take), .pc_next(pc_next)
  );

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hz_fwd_pick #(.RA_W(RA_W)) u_fp (
      .clk(clk), .rst_n(rst_n), .src(ex_src[g]),
      .mem_valid(mem_valid), .mem_we(mem_reg_we), .mem_rd(mem_rd),
      .wb_valid(wb_valid), .wb_we(wb_reg_we), .wb_rd(wb_rd),
      .sel(sel_w[g])
    );
  end

  always_comb begin
    hold        = lu_hit && !take;
    pc_we       = !hold;
    ifid_we     = !hold;
    idex_bubble = hold;
    ifid_flush  = take;
    idex_flush  = take;
    pc_sel      = take;
    fwd_a       = sel_w[0];
    fwd_b       = sel_w[1];
  end

  // R7
  flush_over_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (pc_we && ifid_we && !idex_bubble));

  // R3
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we && ex_is_load));

  // R6
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |-> (pc_next == ex_target && idex_flush));

  // R5
  x0_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !idex_bubble);

  // R10
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |-> (!idex_bubble && !ifid_flush));
endmodule

// File: tb/hz_ctrl_top_tb.sv
module hz_ctrl_top_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic id_valid, id_use_rs1, id_use_rs2, ex_valid, ex_is_load, ex_taken;
  logic mem_valid, mem_reg_we, wb_valid, wb_reg_we;
  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic [31:0] ex_target, cur_pc, pc_next;
  logic pc_we, ifid_we, idex_bubble, ifid_flush, idex_flush, pc_sel;
  logic [1:0] fwd_a, fwd_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [31:0] PC0 = 32'h0000_0100;
  localparam logic [31:0] TGT = 32'h0000_2000;

  always #2 clk = ~clk;

  hz_ctrl_top u_dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .ex_valid(ex_valid),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_is_load(ex_is_load),
    .ex_taken(ex_taken), .ex_target(ex_target), .mem_valid(mem_valid),
    .mem_rd(mem_rd), .mem_reg_we(mem_reg_we), .wb_valid(wb_valid), .wb_rd(wb_rd),
    .wb_reg_we(wb_reg_we), .cur_pc(cur_pc), .pc_we(pc_we), .ifid_we(ifid_we),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush), .idex_flush(idex_flush),
    .pc_sel(pc_sel), .pc_next(pc_next), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  typedef struct packed {
    logic       idv; logic [4:0] rs1; logic [4:0] rs2; logic u1; logic u2;
    logic       exv; logic [4:0] xs1; logic [4:0] xs2; logic [4:0] xrd;
    logic       ld;  logic tk;
    logic       mv;  logic [4:0] mrd; logic mwe;
    logic       wv;  logic [4:0] wrd; logic wwe;
    logic       e_hold; logic e_flush; logic [1:0] e_fa; logic [1:0] e_fb;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{0,3,4,1,1, 0,0,0,7,1,0, 0,0,0, 0,0,0, 0,0,2'b00,2'b00}, // R2 idle
    '{1,3,4,1,1, 1,0,0,7,1,0, 0,0,0, 0,0,0, 0,0,2'b00,2'b00}, // R2 no match
    '{1,3,4,1,1, 1,0,0,3,1,0, 0,0,0, 0,0,0, 1,0,2'b00,2'b00}, // R3 rs1
    '{1,3,4,1,1, 1,0,0,4,1,0, 0,0,0, 0,0,0, 1,0,2'b00,2'b00}, // R3 rs2
    '{1,3,4,1,0, 1,0,0,4,1,0, 0,0,0, 0,0,0, 0,0,2'b00,2'b00}, // R4 unused rs2
    '{1,0,4,1,1, 1,0,0,0,1,0, 0,0,0, 0,0,0, 0,0,2'b00,2'b00}, // R5 x0 load
    '{1,3,4,1,1, 1,0,0,3,1,1, 0,0,0, 0,0,0, 0,1,2'b00,2'b00}, // R7 flush wins
    '{1,3,4,1,1, 1,0,0,9,0,1, 0,0,0, 0,0,0, 0,1,2'b00,2'b00}, // R6 taken
    '{1,3,4,1,1, 1,0,0,3,0,0, 0,0,0, 0,0,0, 0,0,2'b00,2'b00}, // R3 non-load
    '{0,3,4,1,1, 1,0,0,3,1,0, 0,0,0, 0,0,0, 0,0,2'b00,2'b00}, // R10 id invalid
    '{0,0,0,0,0, 1,5,6,1,0,0, 1,5,1, 1,6,1, 0,0,2'b10,2'b01}, // R8 mem/wb
    '{0,0,0,0,0, 1,5,5,1,0,0, 1,5,1, 1,5,1, 0,0,2'b10,2'b10}, // R8 priority
    '{0,0,0,0,0, 1,5,2,1,0,0, 1,5,0, 1,5,1, 0,0,2'b01,2'b00}, // R9 mem no we
    '{0,0,0,0,0, 1,0,0,1,0,0, 1,0,1, 1,0,1, 0,0,2'b00,2'b00}, // R5 x0 bypass
    '{0,0,0,0,0, 1,5,2,1,0,0, 0,5,1, 1,5,1, 0,0,2'b01,2'b00}, // R9 mem invalid
    '{1,3,4,1,1, 0,0,0,3,1,1, 0,0,0, 0,0,0, 0,0,2'b00,2'b00}  // R10 ex invalid
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    id_valid = v.idv; id_rs1 = v.rs1; id_rs2 = v.rs2;
    id_use_rs1 = v.u1; id_use_rs2 = v.u2;
    ex_valid = v.exv; ex_rs1 = v.xs1; ex_rs2 = v.xs2; ex_rd = v.xrd;
    ex_is_load = v.ld; ex_taken = v.tk;
    mem_valid = v.mv; mem_rd = v.mrd; mem_reg_we = v.mwe;
    wb_valid = v.wv; wb_rd = v.wrd; wb_reg_we = v.wwe;
  endtask

  task automatic expect_ctl(input string tag, input logic h, input logic f);
    chk({tag, " pc_we"},   {31'd0, pc_we},       {31'd0, !h});
    chk({tag, " ifid_we"}, {31'd0, ifid_we},     {31'd0, !h});
    chk({tag, " bubble"},  {31'd0, idex_bubble}, {31'd0, h});
    chk({tag, " flush"},   {30'd0, ifid_flush, idex_flush}, {30'd0, f, f});
    chk({tag, " pc_sel"},  {31'd0, pc_sel},      {31'd0, f});
    chk({tag, " pc_next"}, pc_next, f ? TGT : PC0 + 32'd4);
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 1:       return "R2";
      2, 3, 8:    return "R3";
      4:          return "R4";
      5, 13:      return "R5";
      6:          return "R7";
      7:          return "R6";
      9, 15:      return "R10";
      10, 11:     return "R8";
      default:    return "R9";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cur_pc = PC0; ex_target = TGT; rst_n = 1'b0;
    // R1: hostile inputs during and right after reset
    apply(VEC[6]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    expect_ctl("R1 first cycle", 1'b0, 1'b0);
    @(negedge clk); #1;
    expect_ctl("R7 after qualify", 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #1;
      expect_ctl($sformatf("%s vec%0d", vtag(i), i), VEC[i].e_hold, VEC[i].e_flush);
      chk($sformatf("%s vec%0d fwd_a", vtag(i), i), {30'd0, fwd_a}, {30'd0, VEC[i].e_fa});
      chk($sformatf("%s vec%0d fwd_b", vtag(i), i), {30'd0, fwd_b}, {30'd0, VEC[i].e_fb});
    end

    // R3 then R8: load r7 followed by a consumer of r7, one hold then bypass
    @(negedge clk);
    apply('{1,7,2,1,1, 1,0,0,7,1,0, 0,0,0, 0,0,0, 0,0,2'b00,2'b00});
    #1; expect_ctl("R3 seq hold", 1'b1, 1'b0);
    @(negedge clk);
    apply('{1,7,2,1,1, 0,0,0,0,0,0, 1,7,1, 0,0,0, 0,0,2'b00,2'b00});
    #1; expect_ctl("R3 seq bubble cycle", 1'b0, 1'b0);
    @(negedge clk);
    apply('{1,9,9,0,0, 1,7,2,3,0,0, 0,0,0, 1,7,1, 0,0,2'b00,2'b00});
    #1; expect_ctl("R3 seq release", 1'b0, 1'b0);
    chk("R8 seq fwd_a from write-back", {30'd0, fwd_a}, 32'd1);

    // R1: reset again mid-run, first cycle quiet again
    @(negedge clk);
    rst_n = 1'b0;
    apply(VEC[2]);
    @(negedge clk);
    rst_n = 1'b1;
    #1; expect_ctl("R1 re-reset", 1'b0, 1'b0);
    @(negedge clk); #1;
    expect_ctl("R3 after re-reset", 1'b1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule